// File: doc/BRIEF.md
# Memory Access Pattern Generator

This block is a traffic source for measuring how a memory port behaves under load. Once a run is configured and started, it issues a programmed number of accesses to a synchronous request/response port. The access mode sets how each address is formed and which operation is used: sequential reads, sequential writes, increment-in-place, constant stride, random cache lines, or dependent pointer walks.

While a run is in progress, the block counts completed accesses and the cycles from the first accepted request to the last response. Software divides the access count, scaled by the word size, by the cycle count to get bandwidth. Latency is read from a pointer walk, where every request waits for the previous answer. All read data is summed, which gives an end-to-end signature of what came back.

The memory port has a request, write enable, address and write data, and the memory accepts a request by raising ready. The memory returns exactly one response for each accepted request, write or read, and returns them in order. A response never comes back in the cycle its request is accepted.

Top module: `mem_pattern_gen`

## Requirements
- R1: After reset, busy, done and mem_req are 0, and acc_count, cycle_count and rd_sum are 0.
- R2: A start pulse while idle captures every configuration input, clears the counters, sum and done, and sets busy. A start pulse while busy is ignored, along with any configuration change. A start with count 0 raises done in the next cycle without issuing any request.
- R3: Mode code 0 (sequential read) issues only reads, at base_addr+i for i = 0 to count-1, modulo 2^AW. rd_sum is the sum modulo 2^DW of all read data returned in the run.
- R4: Mode code 1 (sequential write) issues only writes of wr_value, at base_addr+i. Write responses do not change rd_sum.
- R5: Mode code 2 (increment in place) handles each address base_addr+i in two steps. It first reads the word, then writes the read value plus 1 back to the same address, and this pair counts as one access. The block never has more than one request outstanding in this mode.
- R6: Mode code 3 (strided read) reads at base_addr + i*stride, modulo 2^AW.
- R7: Mode code 4 (random line read) reads at base_addr + (L & line_mask)*line_words, modulo 2^AW. L is a 16-bit state loaded with seed at start, or with 1 if seed is 0. L advances once per accepted request as L = (L>>1) XOR (L[0] ? 0xB400 : 0).
- R8: Mode code 5 (pointer walk) reads base_addr first. Every later read goes to base_addr plus the low AW bits of the previous read's data. A request is never issued while another is outstanding.
- R9: In codes 0, 1, 3 and 4, a request is presented in every running cycle until count requests are accepted. While ready is low, the request, address, write enable and write data hold unchanged.
- R10: acc_count counts completed accesses. done rises in the cycle after the final response and holds until the next accepted start.
- R11: cycle_count equals the number of cycles from the cycle the first request is accepted through the cycle the last response arrives, both included.
- R12: Mode codes 6 and 7 behave exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run start pulse |
| mode | input | 3 | Access mode code |
| base_addr | input | AW | Region base word address |
| stride | input | AW | Index step for strided mode |
| count | input | CW | Number of accesses in the run |
| line_words | input | AW | Cache-line size in words (random mode) |
| line_mask | input | LW | Mask applied to random line number |
| seed | input | LW | Random state seed |
| wr_value | input | DW | Data for write-only mode |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| acc_count | output | CW | Completed accesses |
| cycle_count | output | CW | Cycles from first accept to last response |
| rd_sum | output | DW | Sum of read data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request word address |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Response valid |
| mem_rdata | input | DW | Response read data |

## Verification
A corrupted index, random state or pointer register shows up on mem_addr at the next accepted request, so comparing each request with a sequence computed ahead of time catches it within one access. A wrong outstanding-request count appears either as a second request during a serial mode or as a stall that stops the run. A stall shows up as a late done or an inflated cycle_count. Counter faults appear only at the end of a run, as a mismatch in acc_count, cycle_count or rd_sum, or as done rising in the wrong cycle.

// File: rtl/mpg_pkg.sv
`timescale 1ns/1ps
package mpg_pkg;
    typedef enum logic [2:0] {
        MODE_RD     = 3'd0,
        MODE_WR     = 3'd1,
        MODE_RMW    = 3'd2,
        MODE_STRIDE = 3'd3,
        MODE_RAND   = 3'd4,
        MODE_CHASE  = 3'd5
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;
endpackage

// File: rtl/mpg_lfsr.sv
`timescale 1ns/1ps
// Galois right-shift pseudo-random line generator
module mpg_lfsr #(
    parameter int W = 16,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         step,
    output logic [W-1:0] value
);
    logic [W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (load) begin
            lfsr_d = (seed == '0) ? W'(1) : seed;
        end else if (step) begin
            lfsr_d = (lfsr_q >> 1) ^ (lfsr_q[0] ? TAPS : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= W'(1);
        else        lfsr_q <= lfsr_d;
    end

    assign value = lfsr_q;
endmodule

// File: rtl/mpg_perf_cnt.sv
`timescale 1ns/1ps
// Access and elapsed-cycle counters for one run
module mpg_perf_cnt #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          accept,
    input  logic          complete,
    input  logic          finish,
    output logic [CW-1:0] acc_cnt,
    output logic [CW-1:0] cyc_cnt
);
    typedef struct packed {
        logic [CW-1:0] acc;
        logic [CW-1:0] cyc;
        logic          armed;
        logic          running;
    } pc_t;

    pc_t pc_d, pc_q;

    always_comb begin
        pc_d = pc_q;
        if (clr) begin
            pc_d       = '0;
            pc_d.armed = 1'b1;
        end else begin
            if (complete) pc_d.acc = pc_q.acc + CW'(1);
            if (pc_q.running || (pc_q.armed && accept)) pc_d.cyc = pc_q.cyc + CW'(1);
            if (pc_q.armed && accept) begin
                pc_d.armed   = 1'b0;
                pc_d.running = 1'b1;
            end
            if (finish) pc_d.running = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign acc_cnt = pc_q.acc;
    assign cyc_cnt = pc_q.cyc;
endmodule

// File: rtl/mem_pattern_gen.sv
`timescale 1ns/1ps
// Configurable memory traffic generator
module mem_pattern_gen
    import mpg_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] stride,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] line_words,
    input  logic [LW-1:0] line_mask,
    input  logic [LW-1:0] seed,
    input  logic [DW-1:0] wr_value,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] acc_count,
    output logic [CW-1:0] cycle_count,
    output logic [DW-1:0] rd_sum,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);
    localparam int NMODES = 6;

    typedef struct packed {
        state_e        state;
        mode_e         mode;
        logic [AW-1:0] base;
        logic [AW-1:0] stride;
        logic [CW-1:0] count;
        logic [AW-1:0] line;
        logic [LW-1:0] mask;
        logic [DW-1:0] wval;
        logic [AW-1:0] idx;
        logic [CW-1:0] issued;
        logic [CW-1:0] outst;
        logic          wr_pend;
        logic [DW-1:0] wbuf;
        logic [DW-1:0] sum;
        logic          done;
    } regs_t;

    regs_t r_d, r_q;

    logic          start_ok;
    logic          serial;
    logic          rmw_wr;
    logic          req;
    logic          accept;
    logic          resp_wr;
    logic          complete;
    logic          finish;
    logic [LW-1:0] lfsr_val;
    logic [LW-1:0] line_num;
    logic [AW-1:0] addr;

    // Request formation from registered state only
    always_comb begin
        serial   = (r_q.mode == MODE_RMW) || (r_q.mode == MODE_CHASE);
        rmw_wr   = (r_q.mode == MODE_RMW) && r_q.wr_pend;
        line_num = lfsr_val & r_q.mask;
        if (r_q.state != ST_RUN)        req = 1'b0;
        else if (rmw_wr)                req = (r_q.outst == '0);
        else                            req = (r_q.issued < r_q.count) &&
                                              (!serial || (r_q.outst == '0));
        if (r_q.mode == MODE_RAND) addr = r_q.base + AW'(line_num) * r_q.line;
        else                       addr = r_q.base + r_q.idx;
    end

    assign start_ok = start && (r_q.state == ST_IDLE);
    assign accept   = req && mem_ready;
    assign resp_wr  = (r_q.mode == MODE_WR) || rmw_wr;
    assign complete = mem_rvalid && ((r_q.mode != MODE_RMW) || r_q.wr_pend);
    assign finish   = complete && ((acc_count + CW'(1)) == r_q.count);

    always_comb begin
        r_d = r_q;
        if (start_ok) begin
            r_d.mode    = (int'(mode) >= NMODES) ? MODE_RD : mode_e'(mode);
            r_d.base    = base_addr;
            r_d.stride  = stride;
            r_d.count   = count;
            r_d.line    = line_words;
            r_d.mask    = line_mask;
            r_d.wval    = wr_value;
            r_d.idx     = '0;
            r_d.issued  = '0;
            r_d.outst   = '0;
            r_d.wr_pend = 1'b0;
            r_d.wbuf    = '0;
            r_d.sum     = '0;
            r_d.done    = (count == '0);
            r_d.state   = (count == '0) ? ST_IDLE : ST_RUN;
        end else if (r_q.state == ST_RUN) begin
            // outstanding bookkeeping
            r_d.outst = r_q.outst + CW'(accept) - CW'(mem_rvalid);
            if (accept && !rmw_wr) r_d.issued = r_q.issued + CW'(1);
            // index advance on accepted requests
            if (accept) begin
                case (r_q.mode)
                    MODE_RD, MODE_WR: r_d.idx = r_q.idx + AW'(1);
                    MODE_STRIDE:      r_d.idx = r_q.idx + r_q.stride;
                    MODE_RMW:         if (rmw_wr) r_d.idx = r_q.idx + AW'(1);
                    default:          r_d.idx = r_q.idx;
                endcase
            end
            // response handling
            if (mem_rvalid) begin
                if (!resp_wr) r_d.sum = r_q.sum + mem_rdata;
                if (r_q.mode == MODE_CHASE) r_d.idx = mem_rdata[AW-1:0];
                if (r_q.mode == MODE_RMW) begin
                    if (r_q.wr_pend) begin
                        r_d.wr_pend = 1'b0;
                    end else begin
                        r_d.wr_pend = 1'b1;
                        r_d.wbuf    = mem_rdata + DW'(1);
                    end
                end
            end
            if (finish) begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.mode  <= MODE_RD;
        end else begin
            r_q <= r_d;
        end
    end

    mpg_lfsr #(.W(LW), .TAPS(LW'(16'hB400))) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_ok),
        .seed  (seed),
        .step  (accept && (r_q.mode == MODE_RAND)),
        .value (lfsr_val)
    );

    mpg_perf_cnt #(.CW(CW)) u_perf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_ok),
        .accept   (accept),
        .complete (complete && (r_q.state == ST_RUN)),
        .finish   (finish && (r_q.state == ST_RUN)),
        .acc_cnt  (acc_count),
        .cyc_cnt  (cycle_count)
    );

    assign busy      = (r_q.state == ST_RUN);
    assign done      = r_q.done;
    assign rd_sum    = r_q.sum;
    assign mem_req   = req;
    assign mem_we    = (r_q.mode == MODE_WR) || rmw_wr;
    assign mem_addr  = addr;
    assign mem_wdata = (r_q.mode == MODE_WR) ? r_q.wval : r_q.wbuf;

    // views of captured configuration for the bound checker
    logic [2:0]    cur_mode;
    logic [CW-1:0] cur_count;
    logic [DW-1:0] cur_wval;
    assign cur_mode  = r_q.mode;
    assign cur_count = r_q.count;
    assign cur_wval  = r_q.wval;
endmodule

// File: rtl/mpg_checker.sv
`timescale 1ns/1ps
module mpg_checker
    import mpg_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [CW-1:0] acc_count,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ready,
    input logic          mem_rvalid,
    input logic [2:0]    cur_mode,
    input logic [CW-1:0] cur_count,
    input logic [DW-1:0] cur_wval
);
    logic [CW-1:0] out_q;
    logic [AW-1:0] rd_addr_q;
    logic          serial_m;
    logic          read_m;

    assign serial_m = (cur_mode == 3'(MODE_RMW)) || (cur_mode == 3'(MODE_CHASE));
    assign read_m   = (cur_mode == 3'(MODE_RD)) || (cur_mode == 3'(MODE_STRIDE)) ||
                      (cur_mode == 3'(MODE_RAND)) || (cur_mode == 3'(MODE_CHASE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q     <= '0;
            rd_addr_q <= '0;
        end else begin
            out_q <= out_q + CW'(mem_req && mem_ready) - CW'(mem_rvalid);
            if (mem_req && mem_ready && !mem_we) rd_addr_q <= mem_addr;
        end
    end

    p_no_req_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    p_hold_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_we) && $stable(mem_wdata)));

    p_single_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_m && out_q != '0) |-> !mem_req);

    p_done_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_acc_below_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (acc_count < cur_count));

    p_write_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'(MODE_WR) && mem_req) |-> (mem_we && mem_wdata == cur_wval));

    p_rmw_same_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'(MODE_RMW) && mem_req && mem_we) |-> (mem_addr == rd_addr_q));

    p_reads_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (read_m && mem_req) |-> !mem_we);
endmodule

bind mem_pattern_gen mpg_checker #(.AW(AW), .DW(DW), .CW(CW)) u_mpg_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .acc_count  (acc_count),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid),
    .cur_mode   (cur_mode),
    .cur_count  (cur_count),
    .cur_wval   (cur_wval)
);

// File: tb/mem_pattern_gen_tb_top.sv
`timescale 1ns/1ps
module mem_pattern_gen_tb_top;
    localparam int AW  = 10;
    localparam int DW  = 32;
    localparam int CW  = 32;
    localparam int LW  = 16;
    localparam int MSZ = 1 << AW;

    typedef struct packed {
        logic [2:0]  mode;
        logic [7:0]  n;
        logic [9:0]  base;
        logic [9:0]  stride;
        logic [7:0]  line;
        logic [7:0]  mask;
        logic [3:0]  dly;
        logic        rdy;
        logic [15:0] seed;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{3'd0, 8'd12, 10'd5,    10'd0,  8'd0,  8'd0,   4'd1, 1'b0, 16'h0000},
        '{3'd0, 8'd10, 10'd1018, 10'd0,  8'd0,  8'd0,   4'd3, 1'b1, 16'h0000},
        '{3'd1, 8'd9,  10'd40,   10'd0,  8'd0,  8'd0,   4'd2, 1'b1, 16'h0000},
        '{3'd2, 8'd7,  10'd100,  10'd0,  8'd0,  8'd0,   4'd1, 1'b0, 16'h0000},
        '{3'd2, 8'd5,  10'd1021, 10'd0,  8'd0,  8'd0,   4'd4, 1'b1, 16'h0000},
        '{3'd3, 8'd11, 10'd7,    10'd33, 8'd0,  8'd0,   4'd2, 1'b0, 16'h0000},
        '{3'd4, 8'd16, 10'd64,   10'd0,  8'd8,  8'h1F,  4'd3, 1'b0, 16'hACE1},
        '{3'd4, 8'd10, 10'd0,    10'd0,  8'd16, 8'h0F,  4'd1, 1'b1, 16'h0000},
        '{3'd5, 8'd14, 10'd200,  10'd0,  8'd0,  8'd0,   4'd2, 1'b0, 16'h0000},
        '{3'd5, 8'd9,  10'd0,    10'd0,  8'd0,  8'd0,   4'd5, 1'b1, 16'h0000},
        '{3'd7, 8'd6,  10'd300,  10'd0,  8'd0,  8'd0,   4'd2, 1'b0, 16'h0000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    mode = '0;
    logic [AW-1:0] base_addr = '0;
    logic [AW-1:0] stride = '0;
    logic [CW-1:0] count = '0;
    logic [AW-1:0] line_words = '0;
    logic [LW-1:0] line_mask = '0;
    logic [LW-1:0] seed = '0;
    logic [DW-1:0] wr_value = '0;
    logic          busy, done;
    logic [CW-1:0] acc_count, cycle_count;
    logic [DW-1:0] rd_sum;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ready = 1'b1;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    always #2 clk = ~clk;

    mem_pattern_gen #(.AW(AW), .DW(DW), .CW(CW), .LW(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .base_addr(base_addr), .stride(stride), .count(count),
        .line_words(line_words), .line_mask(line_mask), .seed(seed),
        .wr_value(wr_value), .busy(busy), .done(done),
        .acc_count(acc_count), .cycle_count(cycle_count), .rd_sum(rd_sum),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // behavioural memory with programmable response delay
    logic [DW-1:0] mem  [MSZ];
    logic [DW-1:0] smem [MSZ];
    logic          pv   [16];
    logic [DW-1:0] pd   [16];
    int dly = 1;
    int rdy_pat = 0;
    int tick = 0;

    initial for (int i = 0; i < 16; i++) begin pv[i] = 1'b0; pd[i] = '0; end

    always @(posedge clk) begin
        int s;
        if (mem_req && mem_ready) begin
            s = (tick + dly) % 16;
            pv[s] = 1'b1;
            pd[s] = mem[mem_addr];
            if (mem_we) mem[mem_addr] = mem_wdata;
        end
        mem_rvalid <= pv[tick % 16];
        mem_rdata  <= pv[tick % 16] ? pd[tick % 16] : 32'hDEAD_BEEF;
        pv[tick % 16] = 1'b0;
        tick = tick + 1;
        mem_ready <= (rdy_pat == 0) ? 1'b1 : ((tick % 3) != 0);
    end

    // expected request stream
    logic [AW-1:0] exp_a  [512];
    logic          exp_we [512];
    logic [DW-1:0] exp_wd [512];
    int            exp_n;
    logic [DW-1:0] exp_sum;

    // port monitor
    int nops, seq_err, first_e, last_e, done_e, outst, viol;
    bit serial_run;

    always @(negedge clk) begin
        if (mem_req && mem_ready) begin
            if (nops == 0) first_e = tick;
            if (serial_run && outst != 0) viol++;
            if (nops >= exp_n) seq_err++;
            else if (mem_addr != exp_a[nops] || mem_we != exp_we[nops] ||
                     (mem_we && mem_wdata != exp_wd[nops])) seq_err++;
            nops++;
            outst++;
        end
        if (mem_rvalid) begin
            last_e = tick;
            outst--;
        end
        if (done && done_e < 0) done_e = tick;
    end

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic init_mem();
        for (int i = 0; i < MSZ; i++) begin
            mem[i]  = (32'(i) * 32'h9E37_79B1) ^ 32'h00A5_0000;
            smem[i] = mem[i];
        end
    endtask

    task automatic build_exp(input vec_t v, input logic [DW-1:0] wval);
        logic [AW-1:0] idx, a;
        logic [15:0]   lf;
        logic [DW-1:0] d;
        idx = '0;
        lf = (v.seed == 16'd0) ? 16'd1 : v.seed;
        exp_n = 0;
        exp_sum = '0;
        for (int i = 0; i < int'(v.n); i++) begin
            case (v.mode)
                3'd1: begin
                    a = v.base + AW'(i);
                    exp_a[exp_n] = a; exp_we[exp_n] = 1'b1; exp_wd[exp_n] = wval; exp_n++;
                    smem[a] = wval;
                end
                3'd2: begin
                    a = v.base + AW'(i);
                    d = smem[a];
                    exp_sum = exp_sum + d;
                    exp_a[exp_n] = a; exp_we[exp_n] = 1'b0; exp_wd[exp_n] = '0; exp_n++;
                    exp_a[exp_n] = a; exp_we[exp_n] = 1'b1; exp_wd[exp_n] = d + 1; exp_n++;
                    smem[a] = d + 1;
                end
                default: begin
                    if (v.mode == 3'd3) begin
                        a = v.base + idx; idx = idx + AW'(v.stride);
                    end else if (v.mode == 3'd4) begin
                        a = v.base + AW'(lf & {8'h00, v.mask}) * AW'(v.line);
                        lf = (lf >> 1) ^ (lf[0] ? 16'hB400 : 16'h0000);
                    end else if (v.mode == 3'd5) begin
                        a = v.base + idx; idx = smem[a][AW-1:0];
                    end else begin
                        a = v.base + AW'(i);
                    end
                    exp_sum = exp_sum + smem[a];
                    exp_a[exp_n] = a; exp_we[exp_n] = 1'b0; exp_wd[exp_n] = '0; exp_n++;
                end
            endcase
        end
    endtask

    task automatic run_case(input vec_t v, input logic [DW-1:0] wval, input bit extra_start);
        string tg;
        int w;
        int mism;
        logic [CW-1:0] acc_hold;
        tg = mode_tag(v.mode);
        init_mem();
        dly = int'(v.dly);
        rdy_pat = int'(v.rdy);
        build_exp(v, wval);
        serial_run = (v.mode == 3'd2) || (v.mode == 3'd5);
        @(negedge clk);
        mode = v.mode; base_addr = v.base; stride = v.stride; count = CW'(v.n);
        line_words = AW'(v.line); line_mask = LW'(v.mask); seed = v.seed; wr_value = wval;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        nops = 0; seq_err = 0; first_e = -1; last_e = -1; done_e = -1; outst = 0; viol = 0;
        if (extra_start) begin
            repeat (3) @(posedge clk);
            #1;
            mode = 3'd1; count = CW'(3); start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
        end
        w = 0;
        while (!done && w < 20000) begin @(negedge clk); w++; end
        @(negedge clk);
        chk(done == 1'b1, "R10", "done raised", longint'(done), 1);
        chk(seq_err == 0, tg, "request stream mismatches", seq_err, 0);
        chk(nops == exp_n, tg, "requests issued", nops, exp_n);
        chk(acc_count == CW'(v.n), "R10", "acc_count", acc_count, v.n);
        chk(rd_sum == exp_sum, tg, "rd_sum", rd_sum, exp_sum);
        chk(done_e == last_e + 1, "R10", "done edge", done_e, last_e + 1);
        chk(cycle_count == CW'(last_e - first_e + 1), "R11", "cycle_count",
            cycle_count, last_e - first_e + 1);
        if (serial_run) chk(viol == 0, tg, "overlapping requests", viol, 0);
        if (!serial_run && v.rdy == 1'b0)
            chk(cycle_count == CW'(int'(v.n) + dly + 1), "R9", "back-to-back cycles",
                cycle_count, int'(v.n) + dly + 1);
        mism = 0;
        for (int i = 0; i < MSZ; i++) if (mem[i] != smem[i]) mism++;
        chk(mism == 0, tg, "memory image words differing", mism, 0);
        acc_hold = acc_count;
        repeat (4) @(negedge clk);
        chk(done == 1'b1 && acc_count == acc_hold && !mem_req, "R10", "done held idle",
            longint'(done), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        init_mem();
        exp_n = 0;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !mem_req, "R1", "busy/done/req after reset",
            longint'({busy, done, mem_req}), 0);
        chk(acc_count == 0 && cycle_count == 0 && rd_sum == 0, "R1", "counters after reset",
            acc_count + cycle_count + rd_sum, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !mem_req, "R1", "idle after release", longint'({busy, mem_req}), 0);

        // table-driven runs across all modes
        for (int k = 0; k < NVEC; k++)
            run_case(VEC[k], 32'h1234_5678 ^ DW'(k), 1'b0);

        // R2: count zero completes at once without requests
        @(negedge clk);
        mode = 3'd0; count = '0; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        chk(done && !busy && !mem_req, "R2", "zero-count run finish",
            longint'({done, busy, mem_req}), 3'b100);
        chk(acc_count == 0 && cycle_count == 0, "R2", "zero-count counters",
            acc_count + cycle_count, 0);

        // R2: start pulse and config change while busy are ignored
        run_case('{3'd5, 8'd6, 10'd500, 10'd0, 8'd0, 8'd0, 4'd3, 1'b0, 16'h0000},
                 32'h0, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule